// File: doc/BRIEF.md
# Slot-Stamped Link Bridge for Time-Division Traffic

This block moves guaranteed-traffic packets over a single one-way link between two routers that run the same time-division slot schedule. The link's delay and the clock skew between its ends are bounded but not known exactly. The sending end writes a target slot number into each packet header. The receiving end queues arriving phits and holds each packet until its own slot counter reaches the target slot. Whatever delay the link adds within its bound, the packet therefore leaves the receiver in a fixed, predictable slot. The receiver keeps no schedule table, only a slot counter.

Both ends are modelled in one clock. A selectable-length register pipe stands in for the link. The slot offset added at the sender is a configuration input. To meet the timing guarantee it should be at least ceil((link delay + 1) / slot length), where the extra cycle counts the write into the receive queue. The stamping logic is combinational on the input path, and the release check sits beside the queue, so neither adds a pipeline stage. Before a packet goes downstream, the receiver clears the stamped field in its header.

Top module: `slot_tag_bridge`

## Requirements
- R1: While rst_n is low, out_valid is low. After reset, both slot counters start at slot 0, phase 0.
- R2: Each end's slot counter advances by one every SLOT_LEN clock cycles and wraps from NUM_SLOTS-1 to 0. The two ends stay in step.
- R3: The header is the first phit accepted after reset or after a phit with in_last set. Its bits [SB-1:0], where SB = clog2(NUM_SLOTS), are overwritten with (sender slot in the acceptance cycle + slot_delta) mod NUM_SLOTS. Payload phits are forwarded unchanged.
- R4: The receiver presents a header phit only in cycles where its slot counter equals the stamped value. Before that cycle, the packet is held.
- R5: When the sender presents a packet's phits on consecutive cycles and the header has been taken downstream, out_valid stays high for every remaining phit until the phit with out_last has been taken.
- R6: On output, header bits [SB-1:0] read zero. All other header bits, and every payload phit, equal what entered.
- R7: While out_valid is high and out_ready is low, out_valid, out_data and out_last hold their values into the next cycle.
- R8: slot_delta accepts any value 0 to NUM_SLOTS-1. Target slots wrap modulo NUM_SLOTS; at NUM_SLOTS-1 the release falls one slot before the sending slot in the next rotation.
- R9: in_ready is always high. With FIFO_DEPTH = NUM_SLOTS*SLOT_LEN, at most one header sent per slot and packets of at most SLOT_LEN phits, the receive queue is never written while full.
- R10: link_dly selects a link delay of 0 to MAX_LINK_DLY cycles. Packets still leave in their stamped slot whenever slot_delta >= ceil((link_dly+1)/SLOT_LEN).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both link ends |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_delta | input | SB | Slot offset added to the sender slot when stamping |
| link_dly | input | DW | Modelled link delay in cycles, 0 to MAX_LINK_DLY |
| in_valid | input | 1 | Sender phit valid |
| in_ready | output | 1 | Sender phit accepted (always high) |
| in_data | input | PHIT_W | Sender phit |
| in_last | input | 1 | Marks the last phit of a packet |
| out_valid | output | 1 | Receiver phit valid |
| out_ready | input | 1 | Downstream accepts the phit |
| out_data | output | PHIT_W | Receiver phit, stamped field cleared in headers |
| out_last | output | 1 | Marks the last phit of a packet |

## Verification
Some behaviours hold in every cycle, and the assertions check these continuously:
- the receive queue is never written while full;
- the two slot counters agree;
- a stalled output holds its value;
- a header leaving the receiver has a zero slot field;
- a packet, once started, streams without gaps.

Whether each header leaves in exactly the slot computed from its sending slot and the offset depends on the whole path. That path covers the stamp, the link delay, the queue and the release compare, so only the bench's scenarios can show it. They do so by modelling the slot count from cycle numbers and replaying packets across several link delays, offsets up to the wrap-around value, and a downstream stall.

// File: rtl/slot_tag_pkg.sv
package slot_tag_pkg;
  typedef enum logic {
    REL_WAIT  = 1'b0,
    REL_BURST = 1'b1
  } rel_state_e;
endpackage

// File: rtl/slot_counter.sv
module slot_counter #(
  parameter int NUM_SLOTS = 8,
  parameter int SLOT_LEN  = 4,
  localparam int SB = $clog2(NUM_SLOTS),
  localparam int PW = $clog2(SLOT_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [SB-1:0] slot
);
  localparam logic [PW-1:0] PH_LAST = PW'(SLOT_LEN - 1);
  localparam logic [SB-1:0] SL_LAST = SB'(NUM_SLOTS - 1);

  logic [PW-1:0] phase_q, phase_d;
  logic [SB-1:0] slot_q, slot_d;

  always_comb begin
    phase_d = phase_q + PW'(1);
    slot_d  = slot_q;
    if (phase_q == PH_LAST) begin
      phase_d = '0;
      slot_d  = (slot_q == SL_LAST) ? '0 : slot_q + SB'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      slot_q  <= '0;
    end else begin
      phase_q <= phase_d;
      slot_q  <= slot_d;
    end
  end

  assign slot = slot_q;
endmodule

// File: rtl/slot_coder.sv
module slot_coder #(
  parameter int PHIT_W    = 16,
  parameter int NUM_SLOTS = 8,
  localparam int SB = $clog2(NUM_SLOTS),
  localparam int SW = SB + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SB-1:0]     tx_slot,
  input  logic [SB-1:0]     delta,
  input  logic              in_valid,
  input  logic [PHIT_W-1:0] in_data,
  input  logic              in_last,
  output logic              cod_valid,
  output logic              cod_first,
  output logic              cod_last,
  output logic [PHIT_W-1:0] cod_data
);
  localparam logic [SW-1:0] NS = SW'(NUM_SLOTS);

  logic          first_q, first_d;
  logic [SW-1:0] sum;
  logic [SB-1:0] target;

  always_comb begin
    sum = {1'b0, tx_slot} + {1'b0, delta};
    if (sum >= NS) sum = sum - NS;
    target = sum[SB-1:0];
  end

  always_comb begin
    first_d = first_q;
    if (in_valid) first_d = in_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) first_q <= 1'b1;
    else        first_q <= first_d;
  end

  assign cod_valid = in_valid;
  assign cod_first = first_q;
  assign cod_last  = in_last;
  assign cod_data  = first_q ? {in_data[PHIT_W-1:SB], target} : in_data;
endmodule

// File: rtl/link_delay.sv
module link_delay #(
  parameter int PL_W    = 18,
  parameter int MAX_DLY = 6,
  localparam int DW = $clog2(MAX_DLY + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   sel,
  input  logic            in_v,
  input  logic [PL_W-1:0] in_pl,
  output logic            out_v,
  output logic [PL_W-1:0] out_pl
);
  logic [MAX_DLY-1:0] v_q;
  logic [PL_W-1:0]    d_q [MAX_DLY];
  logic [DW-1:0]      sel_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= '0;
    else        v_q <= {v_q[MAX_DLY-2:0], in_v};
  end

  always_ff @(posedge clk) begin
    if (in_v) d_q[0] <= in_pl;
    for (int k = 1; k < MAX_DLY; k++) begin
      if (v_q[k-1]) d_q[k] <= d_q[k-1];
    end
  end

  assign sel_c = (sel > DW'(MAX_DLY)) ? DW'(MAX_DLY) : sel;

  always_comb begin
    out_v  = in_v;
    out_pl = in_pl;
    for (int k = 1; k <= MAX_DLY; k++) begin
      if (sel_c == DW'(k)) begin
        out_v  = v_q[k-1];
        out_pl = d_q[k-1];
      end
    end
  end
endmodule

// File: rtl/phit_fifo.sv
module phit_fifo #(
  parameter int WIDTH = 18,
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam logic [AW-1:0] P_LAST = AW'(DEPTH - 1);
  localparam logic [AW:0]   C_FULL = (AW+1)'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp_q, wp_d, rp_q, rp_d;
  logic [AW:0]      cnt_q, cnt_d;
  logic             do_wr, do_rd;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == C_FULL);
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;
  assign head  = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_wr) wp_d = (wp_q == P_LAST) ? '0 : wp_q + AW'(1);
    if (do_rd) rp_d = (rp_q == P_LAST) ? '0 : rp_q + AW'(1);
    if (do_wr && !do_rd) cnt_d = cnt_q + (AW+1)'(1);
    if (do_rd && !do_wr) cnt_d = cnt_q - (AW+1)'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp_q] <= wr_data;
  end
endmodule

// File: rtl/slot_tag_bridge.sv
module slot_tag_bridge
  import slot_tag_pkg::*;
#(
  parameter int PHIT_W       = 16,
  parameter int NUM_SLOTS    = 8,
  parameter int SLOT_LEN     = 4,
  parameter int MAX_LINK_DLY = 6,
  parameter int FIFO_DEPTH   = NUM_SLOTS * SLOT_LEN,
  localparam int SB   = $clog2(NUM_SLOTS),
  localparam int DW   = $clog2(MAX_LINK_DLY + 1),
  localparam int PL_W = PHIT_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SB-1:0]     slot_delta,
  input  logic [DW-1:0]     link_dly,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PHIT_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PHIT_W-1:0] out_data,
  output logic              out_last
);
  logic [SB-1:0]     tx_slot, rx_slot;
  logic              cod_valid, cod_first, cod_last;
  logic [PHIT_W-1:0] cod_data;
  logic              lnk_v;
  logic [PL_W-1:0]   lnk_pl;
  logic              fifo_wr, fifo_rd, fifo_empty, fifo_full;
  logic [PL_W-1:0]   fifo_head;
  logic              head_first, head_last, slot_hit, streaming;
  logic [PHIT_W-1:0] head_data;
  rel_state_e        state_q, state_d;

  assign in_ready = 1'b1;

  slot_counter #(.NUM_SLOTS(NUM_SLOTS), .SLOT_LEN(SLOT_LEN)) u_tx_cnt (
    .clk(clk), .rst_n(rst_n), .slot(tx_slot));

  slot_counter #(.NUM_SLOTS(NUM_SLOTS), .SLOT_LEN(SLOT_LEN)) u_rx_cnt (
    .clk(clk), .rst_n(rst_n), .slot(rx_slot));

  slot_coder #(.PHIT_W(PHIT_W), .NUM_SLOTS(NUM_SLOTS)) u_coder (
    .clk(clk), .rst_n(rst_n), .tx_slot(tx_slot), .delta(slot_delta),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .cod_valid(cod_valid), .cod_first(cod_first), .cod_last(cod_last),
    .cod_data(cod_data));

  link_delay #(.PL_W(PL_W), .MAX_DLY(MAX_LINK_DLY)) u_link (
    .clk(clk), .rst_n(rst_n), .sel(link_dly),
    .in_v(cod_valid), .in_pl({cod_first, cod_last, cod_data}),
    .out_v(lnk_v), .out_pl(lnk_pl));

  assign fifo_wr = lnk_v;

  phit_fifo #(.WIDTH(PL_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(fifo_wr), .wr_data(lnk_pl),
    .rd_en(fifo_rd), .head(fifo_head), .empty(fifo_empty), .full(fifo_full));

  assign {head_first, head_last, head_data} = fifo_head;
  assign streaming = (state_q == REL_BURST);
  assign slot_hit  = head_first && (head_data[SB-1:0] == rx_slot);

  assign out_valid = !fifo_empty && (streaming || slot_hit);
  assign fifo_rd   = out_valid && out_ready;
  assign out_last  = head_last;
  assign out_data  = head_first ? {head_data[PHIT_W-1:SB], {SB{1'b0}}} : head_data;

  always_comb begin
    state_d = state_q;
    if (fifo_rd) state_d = head_last ? REL_WAIT : REL_BURST;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= REL_WAIT;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/slot_tag_bridge_chk.sv
module slot_tag_bridge_chk #(
  parameter int PHIT_W = 16,
  parameter int SB     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic [PHIT_W-1:0] out_data,
  input logic              out_last,
  input logic              fifo_wr,
  input logic              fifo_full,
  input logic [SB-1:0]     tx_slot,
  input logic [SB-1:0]     rx_slot,
  input logic              streaming
);
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_idle_in_reset: assert (!out_valid);
    end
  end

  a_r2_ends_in_step: assert property (@(posedge clk) disable iff (!rst_n)
    tx_slot == rx_slot);

  a_r5_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    streaming |-> out_valid);

  a_r6_field_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !streaming) |-> (out_data[SB-1:0] == '0));

  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> !fifo_full);
endmodule

bind slot_tag_bridge slot_tag_bridge_chk #(.PHIT_W(PHIT_W), .SB(SB)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_last(out_last), .fifo_wr(fifo_wr),
  .fifo_full(fifo_full), .tx_slot(tx_slot), .rx_slot(rx_slot),
  .streaming(streaming));

// File: tb/test_slot_tag_bridge.sv
module test_slot_tag_bridge;
  localparam int S    = 8;
  localparam int LS   = 4;
  localparam int W    = 16;
  localparam int MAXD = 6;
  localparam int SB   = 3;
  localparam int DW   = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [SB-1:0] slot_delta;
  logic [DW-1:0] link_dly;
  logic          in_valid, in_ready, in_last;
  logic [W-1:0]  in_data;
  logic          out_valid, out_ready, out_last;
  logic [W-1:0]  out_data;

  always #10 clk = ~clk;

  slot_tag_bridge #(.PHIT_W(W), .NUM_SLOTS(S), .SLOT_LEN(LS), .MAX_LINK_DLY(MAXD))
    i_slot_tag_bridge (
      .clk(clk), .rst_n(rst_n), .slot_delta(slot_delta), .link_dly(link_dly),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_last(out_last));

  typedef struct {
    logic [W-1:0] d;
    logic         l;
    logic         h;
    int           slot;
  } exp_t;

  exp_t q[$];
  int   cyc;
  int   n_chk = 0;
  int   n_fail = 0;
  int   delta;
  bit   mid;
  bit   stl;
  logic [W-1:0] stl_d;
  logic         stl_l;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Monitor: pops expected phits and compares; slot model from cycle count (R2).
  always @(negedge clk) begin
    exp_t e;
    if (!rst_n) begin
      mid = 0;
      stl = 0;
    end else begin
      if (stl) begin
        check(out_valid == 1'b1, "R7", "valid held", out_valid, 1);
        check(out_data == stl_d && out_last == stl_l, "R7", "data held", out_data, stl_d);
      end
      stl   = out_valid && !out_ready;
      stl_d = out_data;
      stl_l = out_last;
      if (mid && out_ready) check(out_valid == 1'b1, "R5", "burst gap", out_valid, 1);
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          check(1'b0, "R4", "unexpected phit", out_data, 0);
        end else begin
          e = q.pop_front();
          check(out_data == e.d, e.h ? "R6" : "R3", "phit data", out_data, e.d);
          check(out_last == e.l, "R5", "last flag", out_last, e.l);
          if (e.h) check(((cyc / LS) % S) == e.slot, "R4", "release slot",
                         (cyc / LS) % S, e.slot);
          mid = !out_last;
        end
      end
    end
  end

  // Driver: one header per slot, packet fits within its sending slot.
  task automatic send_pkt(input int len);
    exp_t e;
    logic [W-1:0] d;
    int off;
    while ((cyc % LS) != 0) @(negedge clk);
    off = $urandom_range(LS - len, 0);
    repeat (off) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      d        = W'($urandom);
      in_valid = 1'b1;
      in_data  = d;
      in_last  = (i == len - 1);
      if (i == 0) begin
        e.d    = {d[W-1:SB], {SB{1'b0}}};
        e.h    = 1'b1;
        e.slot = ((cyc / LS) + delta) % S;  // R3 stamp, R8 wrap
      end else begin
        e.d = d;
        e.h = 1'b0;
      end
      e.l = in_last;
      q.push_back(e);
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic flush();
    int guard = 0;
    while (q.size() != 0 && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    repeat (S * LS) @(negedge clk);
    check(q.size() == 0, "R4", "all packets released", q.size(), 0);
  endtask

  task automatic set_link(input int d, input int dl);
    link_dly   = DW'(d);
    delta      = dl;
    slot_delta = SB'(dl);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_data = '0;
    out_ready = 1'b1;
    set_link(0, 1);
    // R1: idle during reset, R9: always ready
    repeat (3) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R1", "valid in reset", out_valid, 0);
      check(in_ready == 1'b1, "R9", "in_ready", in_ready, 1);
    end
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "valid after reset", out_valid, 0);

    // R10 short delay, minimal offset
    set_link(2, 1);
    for (int i = 0; i < 6; i++) send_pkt(1 + (i % LS));
    flush();

    // R10 longest delay, offset 2, wraps past slot S-1 (R2)
    set_link(MAXD, 2);
    for (int i = 0; i < 10; i++) send_pkt(LS - (i % LS));
    flush();

    // R8: largest offset, zero delay (R10)
    set_link(0, S - 1);
    for (int i = 0; i < 10; i++) send_pkt($urandom_range(LS, 1));
    flush();

    // R7: downstream stall inside a packet
    set_link(3, 1);
    fork
      send_pkt(LS);
      begin
        @(posedge clk iff mid);
        #2 out_ready = 1'b0;
        repeat (3) @(posedge clk);
        #2 out_ready = 1'b1;
      end
    join
    flush();

    // Random delays within bounds, offset at or above the rule (R10)
    for (int g = 0; g < 4; g++) begin
      int d = $urandom_range(MAXD, 0);
      int dl = (d + 1 + LS - 1) / LS + $urandom_range(1, 0);
      if (dl > S - 1) dl = S - 1;
      set_link(d, dl);
      for (int i = 0; i < 6; i++) send_pkt($urandom_range(LS, 1));
      flush();
    end

    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R4 watchdog: actual 0 expected 1");
    summary();
    $finish;
  end
endmodule